// File: doc/BRIEF.md
# Shared SMBus Port Selector with Ownership Semaphore

This block lets several bus agents share a single SMBus host engine whose clock and data lines can be steered to any one of four physical ports. An agent takes the engine by writing a request bit into a semaphore register. It then reads that register back. Only the agent that holds the engine sees the request bit as 1. The owner hands the engine back by writing a separate release bit.

Port steering is reached indirectly. An agent writes a configuration index to one register and then reads or writes the addressed configuration byte through a second register. Two configuration bytes can each carry the 2-bit port field. A mode byte picks which of the two drives the routing. An elaboration parameter picks where the field sits inside the byte. The lines are open-drain: a 1 on an output-enable pulls the line low.

Register map on `bus_addr_i`:
- 0: semaphore.
- 1: index.
- 2: data window.
- 3: reserved, reads 0.

Bus reads are combinational. Bus writes take effect at the next rising clock edge.

Top module: `smb_port_share`

## Requirements
- R1: After reset no agent owns the engine, the index and mode byte are 0x00, both select bytes hold SEL_RST (default 0x00), and port 0 is routed.
- R2: A write to address 0 with bit 4 set and bit 5 clear, while the engine is free, makes the writing agent the owner. From the next cycle, a read of address 0 by that agent returns bit 4 = 1.
- R3: While one agent owns the engine, a request by any other agent leaves ownership unchanged. A read of address 0 by that other agent returns bit 4 = 0.
- R4: A write to address 0 with bit 5 set releases the engine only if the writer is the owner. It is ignored for any other agent. A write with bit 5 set never grants ownership, even when bit 4 is also set.
- R5: A read of address 0 returns bit 0 = 1 whenever any agent owns the engine. Bits 7:5 and 3:1 read 0.
- R6: Address 1 holds an 8-bit index that reads back as written.
- R7: Address 2 reads and writes the configuration byte selected by the index:
  - mode byte at 0x10;
  - select byte A at 0x11;
  - select byte B at 0x12.
  Any other index reads 0x00, and writes to it change nothing. A read of address 3 returns 0x00. Routing changes only on a write to address 2.
- R8: Bit 0 of the mode byte chooses the active select byte: 0 picks byte A (0x11), 1 picks byte B (0x12).
- R9: The port field is bits 2:1 when FIELD_HI = 0 and bits 4:3 when FIELD_HI = 1. A write to a select byte updates only the field. The other bits keep their reset value.
- R10: Only the routed port's output-enables follow the engine's. All other ports' output-enables stay 0. The engine's line inputs come from the routed port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_agent_i | input | AGENT_W | Identity of the accessing agent |
| bus_rdata_o | output | 8 | Read data; 0 when not reading |
| eng_scl_oe_i | input | 1 | Engine pulls SCL low |
| eng_sda_oe_i | input | 1 | Engine pulls SDA low |
| eng_scl_o | output | 1 | SCL level seen at the routed port |
| eng_sda_o | output | 1 | SDA level seen at the routed port |
| port_scl_i | input | 4 | SCL level of each port |
| port_sda_i | input | 4 | SDA level of each port |
| port_scl_oe_o | output | 4 | SCL pull-low per port |
| port_sda_oe_o | output | 4 | SDA pull-low per port |

## Verification
A wrong owner or a lost grant shows up in the very next read of address 0: the request bit or the busy bit differs for the agent that reads. A corrupted select byte or mode bit shows up in the same cycle at the per-port output-enables and at the engine's line inputs, because routing is purely combinational from the stored bytes. The bench drives changing engine and port line patterns on every cycle. A routing error therefore appears within one clock and is not masked by idle lines.

// File: rtl/smb_sel_pkg.sv
package smb_sel_pkg;
  typedef enum logic [1:0] {
    REG_SEM = 2'd0,
    REG_IDX = 2'd1,
    REG_DAT = 2'd2,
    REG_RSV = 2'd3
  } reg_addr_e;

  localparam int unsigned SEM_BUSY_BIT = 0;
  localparam int unsigned SEM_REQ_BIT  = 4;
  localparam int unsigned SEM_REL_BIT  = 5;
  localparam int unsigned FIELD_W      = 2;
endpackage

// File: rtl/smb_sem.sv
module smb_sem #(
  parameter int unsigned AGENT_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [7:0]         wdata_i,
  input  logic [AGENT_W-1:0] agent_i,
  output logic               held_o,
  output logic [AGENT_W-1:0] owner_o
);
  import smb_sel_pkg::*;

  logic               held_q;
  logic [AGENT_W-1:0] owner_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else if (wr_i) begin
      // a release bit in the write suppresses any request in the same write
      if (wdata_i[SEM_REL_BIT]) begin
        if (held_q && owner_q == agent_i) held_q <= 1'b0;
      end else if (wdata_i[SEM_REQ_BIT] && !held_q) begin
        held_q  <= 1'b1;
        owner_q <= agent_i;
      end
    end
  end

  assign held_o  = held_q;
  assign owner_o = owner_q;
endmodule

// File: rtl/smb_cfg.sv
module smb_cfg #(
  parameter logic [7:0] IDX_MODE  = 8'h10,
  parameter logic [7:0] IDX_SEL_A = 8'h11,
  parameter logic [7:0] IDX_SEL_B = 8'h12,
  parameter bit         FIELD_HI  = 1'b0,
  parameter logic [7:0] SEL_RST   = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_idx_i,
  input  logic       wr_dat_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] index_o,
  output logic [7:0] dat_o,
  output logic [smb_sel_pkg::FIELD_W-1:0] port_sel_o
);
  import smb_sel_pkg::*;

  localparam int unsigned FIELD_LSB = FIELD_HI ? 3 : 1;
  localparam logic [7:0]  FIELD_MSK = 8'(2'b11) << FIELD_LSB;

  logic [7:0] index_q, mode_q, sel_a_q, sel_b_q, active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      mode_q  <= '0;
      sel_a_q <= SEL_RST;
      sel_b_q <= SEL_RST;
    end else begin
      if (wr_idx_i) index_q <= wdata_i;
      if (wr_dat_i) begin
        if (index_q == IDX_MODE)  mode_q  <= wdata_i;
        if (index_q == IDX_SEL_A) sel_a_q <= (sel_a_q & ~FIELD_MSK) | (wdata_i & FIELD_MSK);
        if (index_q == IDX_SEL_B) sel_b_q <= (sel_b_q & ~FIELD_MSK) | (wdata_i & FIELD_MSK);
      end
    end
  end

  always_comb begin
    dat_o = '0;
    if (index_q == IDX_MODE)  dat_o = mode_q;
    if (index_q == IDX_SEL_A) dat_o = sel_a_q;
    if (index_q == IDX_SEL_B) dat_o = sel_b_q;
  end

  assign active  = mode_q[0] ? sel_b_q : sel_a_q;
  assign index_o = index_q;

  generate
    if (FIELD_HI) begin : g_field_hi
      assign port_sel_o = active[4:3];
    end else begin : g_field_lo
      assign port_sel_o = active[2:1];
    end
  endgenerate
endmodule

// File: rtl/smb_route.sv
module smb_route #(
  parameter int unsigned N_PORTS = 4,
  localparam int unsigned SEL_W  = $clog2(N_PORTS)
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               eng_scl_oe_i,
  input  logic               eng_sda_oe_i,
  output logic               eng_scl_o,
  output logic               eng_sda_o,
  input  logic [N_PORTS-1:0] port_scl_i,
  input  logic [N_PORTS-1:0] port_sda_i,
  output logic [N_PORTS-1:0] port_scl_oe_o,
  output logic [N_PORTS-1:0] port_sda_oe_o
);
  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic hit;
      assign hit              = (sel_i == SEL_W'(p));
      assign port_scl_oe_o[p] = hit & eng_scl_oe_i;
      assign port_sda_oe_o[p] = hit & eng_sda_oe_i;
    end
  endgenerate

  assign eng_scl_o = port_scl_i[sel_i];
  assign eng_sda_o = port_sda_i[sel_i];
endmodule

// File: rtl/smb_port_share.sv
module smb_port_share #(
  parameter int unsigned N_AGENTS  = 4,
  parameter logic [7:0]  IDX_MODE  = 8'h10,
  parameter logic [7:0]  IDX_SEL_A = 8'h11,
  parameter logic [7:0]  IDX_SEL_B = 8'h12,
  parameter bit          FIELD_HI  = 1'b0,
  parameter logic [7:0]  SEL_RST   = 8'h00,
  localparam int unsigned AGENT_W  = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1,
  localparam int unsigned N_PORTS  = 1 << smb_sel_pkg::FIELD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_valid_i,
  input  logic               bus_we_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [7:0]         bus_wdata_i,
  input  logic [AGENT_W-1:0] bus_agent_i,
  output logic [7:0]         bus_rdata_o,
  input  logic               eng_scl_oe_i,
  input  logic               eng_sda_oe_i,
  output logic               eng_scl_o,
  output logic               eng_sda_o,
  input  logic [N_PORTS-1:0] port_scl_i,
  input  logic [N_PORTS-1:0] port_sda_i,
  output logic [N_PORTS-1:0] port_scl_oe_o,
  output logic [N_PORTS-1:0] port_sda_oe_o
);
  import smb_sel_pkg::*;

  logic               wr, rd;
  logic               sem_held;
  logic [AGENT_W-1:0] sem_owner;
  logic [7:0]         cfg_index, cfg_dat;
  logic [FIELD_W-1:0] port_sel;

  assign wr = bus_valid_i & bus_we_i;
  assign rd = bus_valid_i & ~bus_we_i;

  smb_sem #(.AGENT_W(AGENT_W)) u_sem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr && bus_addr_i == REG_SEM),
    .wdata_i (bus_wdata_i),
    .agent_i (bus_agent_i),
    .held_o  (sem_held),
    .owner_o (sem_owner)
  );

  smb_cfg #(
    .IDX_MODE (IDX_MODE),
    .IDX_SEL_A(IDX_SEL_A),
    .IDX_SEL_B(IDX_SEL_B),
    .FIELD_HI (FIELD_HI),
    .SEL_RST  (SEL_RST)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_idx_i  (wr && bus_addr_i == REG_IDX),
    .wr_dat_i  (wr && bus_addr_i == REG_DAT),
    .wdata_i   (bus_wdata_i),
    .index_o   (cfg_index),
    .dat_o     (cfg_dat),
    .port_sel_o(port_sel)
  );

  smb_route #(.N_PORTS(N_PORTS)) u_route (
    .sel_i        (port_sel),
    .eng_scl_oe_i (eng_scl_oe_i),
    .eng_sda_oe_i (eng_sda_oe_i),
    .eng_scl_o    (eng_scl_o),
    .eng_sda_o    (eng_sda_o),
    .port_scl_i   (port_scl_i),
    .port_sda_i   (port_sda_i),
    .port_scl_oe_o(port_scl_oe_o),
    .port_sda_oe_o(port_sda_oe_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      unique case (bus_addr_i)
        REG_SEM: begin
          bus_rdata_o[SEM_BUSY_BIT] = sem_held;
          bus_rdata_o[SEM_REQ_BIT]  = sem_held && (sem_owner == bus_agent_i);
        end
        REG_IDX: bus_rdata_o = cfg_index;
        REG_DAT: bus_rdata_o = cfg_dat;
        default: bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/smb_port_share_chk.sv
module smb_port_share_chk #(
  parameter int unsigned AGENT_W = 2,
  parameter int unsigned N_PORTS = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       bus_valid_i,
  input logic                       bus_we_i,
  input logic [1:0]                 bus_addr_i,
  input logic [7:0]                 bus_wdata_i,
  input logic [AGENT_W-1:0]         bus_agent_i,
  input logic                       sem_held,
  input logic [AGENT_W-1:0]         sem_owner,
  input logic [$clog2(N_PORTS)-1:0] port_sel,
  input logic                       eng_scl_oe_i,
  input logic                       eng_sda_oe_i,
  input logic [N_PORTS-1:0]         port_scl_oe_o,
  input logic [N_PORTS-1:0]         port_sda_oe_o
);
  logic sem_wr, dat_wr;
  assign sem_wr = bus_valid_i && bus_we_i && bus_addr_i == 2'd0;
  assign dat_wr = bus_valid_i && bus_we_i && bus_addr_i == 2'd2;

  // R2
  grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sem_wr && bus_wdata_i[4] && !bus_wdata_i[5] && !sem_held)
    |=> (sem_held && sem_owner == $past(bus_agent_i)));

  // R3
  keep_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sem_wr && sem_held && bus_agent_i != sem_owner) |=> (sem_held && $stable(sem_owner)));

  // R4
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sem_wr && bus_wdata_i[5] && sem_held && bus_agent_i == sem_owner) |=> !sem_held);

  // R7
  sel_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_wr |=> $stable(port_sel));

  // R10
  route_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(port_scl_oe_o) && $onehot0(port_sda_oe_o));

  // R10
  route_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_scl_oe_i |-> port_scl_oe_o == '0);

  // R10
  route_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_sda_oe_i |-> port_sda_oe_o[port_sel]);
endmodule

bind smb_port_share smb_port_share_chk #(.AGENT_W(AGENT_W), .N_PORTS(N_PORTS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_valid_i  (bus_valid_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_agent_i  (bus_agent_i),
  .sem_held     (sem_held),
  .sem_owner    (sem_owner),
  .port_sel     (port_sel),
  .eng_scl_oe_i (eng_scl_oe_i),
  .eng_sda_oe_i (eng_sda_oe_i),
  .port_scl_oe_o(port_scl_oe_o),
  .port_sda_oe_o(port_sda_oe_o)
);

// File: tb/sim_smb_port_share.sv
module sim_smb_port_share;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0, we = 1'b0;
  logic [1:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [AW-1:0] agent = '0;
  logic [7:0]    rdata;
  logic          e_scl_oe = 1'b0, e_sda_oe = 1'b0;
  logic          e_scl, e_sda;
  logic [3:0]    p_scl = 4'hF, p_sda = 4'hF;
  logic [3:0]    p_scl_oe, p_sda_oe;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  int m_held = 0, m_owner = 0, m_idx = 0, m_mode = 0, m_sela = 0, m_selb = 0;

  always #10 clk = ~clk;

  smb_port_share u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(valid), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_agent_i(agent), .bus_rdata_o(rdata),
    .eng_scl_oe_i(e_scl_oe), .eng_sda_oe_i(e_sda_oe),
    .eng_scl_o(e_scl), .eng_sda_o(e_sda),
    .port_scl_i(p_scl), .port_sda_i(p_sda),
    .port_scl_oe_o(p_scl_oe), .port_sda_oe_o(p_sda_oe)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    if (!(valid && !we)) return 0;
    case (addr)
      2'd0: return (m_held ? 8'h01 : 0) | ((m_held && m_owner == int'(agent)) ? 8'h10 : 0);
      2'd1: return m_idx;
      2'd2: return (m_idx == 16) ? m_mode : (m_idx == 17) ? m_sela : (m_idx == 18) ? m_selb : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_port();
    int act = (m_mode & 1) ? m_selb : m_sela;
    return (act >> 1) & 3;
  endfunction

  task automatic model_step();
    int wd = int'(wdata);
    if (!(valid && we)) return;
    case (addr)
      2'd0: begin
        if (wd & 8'h20) begin
          if (m_held && m_owner == int'(agent)) m_held = 0;
        end else if ((wd & 8'h10) && !m_held) begin
          m_held = 1; m_owner = int'(agent);
        end
      end
      2'd1: m_idx = wd;
      2'd2: begin
        if (m_idx == 16) m_mode = wd;
        if (m_idx == 17) m_sela = (m_sela & ~6) | (wd & 6);
        if (m_idx == 18) m_selb = (m_selb & ~6) | (wd & 6);
      end
      default: ;
    endcase
  endtask

  // one bus cycle: drive at negedge, compare mid-low phase, update model after posedge
  task automatic cycle(bit v, bit w, int a, int d, int ag, string tag);
    int p;
    @(negedge clk);
    valid = v; we = w; addr = a[1:0]; wdata = d[7:0]; agent = ag[AW-1:0];
    cyc++;
    e_scl_oe = cyc[0];
    e_sda_oe = cyc[1];
    p_scl = 4'(cyc >> 2);
    p_sda = ~4'(cyc >> 3);
    #2;
    p = exp_port();
    chk({tag, " rdata"}, int'(rdata), exp_rdata());
    chk({tag, " scl_oe"}, int'(p_scl_oe), e_scl_oe ? (1 << p) : 0);
    chk({tag, " sda_oe"}, int'(p_sda_oe), e_sda_oe ? (1 << p) : 0);
    chk({tag, " eng_scl"}, int'(e_scl), int'(p_scl[p]));
    chk({tag, " eng_sda"}, int'(e_sda), int'(p_sda[p]));
    @(posedge clk);
    #1;
    if (rst_n) model_step();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cycle(0, 0, 0, 0, 0, "R1");
    cycle(0, 0, 0, 0, 0, "R1");
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state visible through reads and routing
    cycle(1, 0, 0, 0, 1, "R1");
    cycle(1, 0, 1, 0, 1, "R1");
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 0, "R10");
    // R2 grant and readback
    cycle(1, 1, 0, 8'h10, 1, "R2");
    cycle(1, 0, 0, 0, 1, "R2");
    cycle(1, 0, 0, 0, 2, "R5");
    // R3 competing request
    cycle(1, 1, 0, 8'h10, 2, "R3");
    cycle(1, 0, 0, 0, 2, "R3");
    cycle(1, 0, 0, 0, 1, "R3");
    // R4 release by non-owner ignored
    cycle(1, 1, 0, 8'h20, 2, "R4");
    cycle(1, 0, 0, 0, 1, "R4");
    // R6 index, R7/R9 select byte A field-only write
    cycle(1, 1, 1, 8'h11, 1, "R6");
    cycle(1, 0, 1, 0, 1, "R6");
    cycle(1, 1, 2, 8'hFF, 1, "R9");
    cycle(1, 0, 2, 0, 1, "R9");
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 0, "R10");
    // R8 select byte B, then mode bit
    cycle(1, 1, 1, 8'h12, 1, "R8");
    cycle(1, 1, 2, 8'h02, 1, "R8");
    cycle(1, 0, 2, 0, 1, "R8");
    cycle(0, 0, 0, 0, 0, "R8");
    cycle(1, 1, 1, 8'h10, 1, "R8");
    cycle(1, 1, 2, 8'h01, 1, "R8");
    cycle(1, 0, 2, 0, 1, "R8");
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 0, "R10");
    // R7 unknown index ignored, reserved address
    cycle(1, 1, 1, 8'h33, 1, "R7");
    cycle(1, 1, 2, 8'hAA, 1, "R7");
    cycle(1, 0, 2, 0, 1, "R7");
    cycle(1, 0, 3, 0, 1, "R7");
    cycle(0, 0, 0, 0, 0, "R7");
    // R9 bits outside the field keep reset value
    cycle(1, 1, 1, 8'h12, 0, "R9");
    cycle(1, 1, 2, 8'hF9, 0, "R9");
    cycle(1, 0, 2, 0, 0, "R9");
    cycle(0, 0, 0, 0, 0, "R9");
    // R4 owner release, then combined bits on free engine do not grant
    cycle(1, 1, 0, 8'h30, 1, "R4");
    cycle(1, 0, 0, 0, 0, "R4");
    cycle(1, 1, 0, 8'h30, 3, "R4");
    cycle(1, 0, 0, 0, 3, "R4");
    cycle(1, 1, 0, 8'h10, 3, "R2");
    cycle(1, 0, 0, 0, 3, "R2");
    cycle(1, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 6; i++) cycle(0, 0, 0, 0, 0, "R10");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule